// File: doc/BRIEF.md
# MII Receive Deframer

This block takes the four-bit receive stream of a media-independent interface (nibble data, a data-valid strobe and a receive-error strobe) on the receive clock. It searches for the start-of-frame delimiter and then packs the nibbles that follow into bytes. The delimiter may come after a preamble of any length, including none. Bytes leave on a plain valid/data/last/error interface.

One byte is held back until the next byte completes or the frame ends, so the final complete byte can carry the last flag. A one-cycle frame-done pulse reports whether the frame was errored or misaligned. Collision and carrier-sense inputs are registered and passed to the host. Collision is forced low while full duplex is selected.

Top module: `mii_rx_deframer`

## Requirements
- R1: While reset is asserted and until the first frame, every output is low.
- R2: In the hunt state, a nibble 0x5 followed directly by nibble 0xD locks the block. This is the delimiter byte 0xD5 sent low nibble first. Locking works with a full seven-byte preamble, a shortened one, or none at all. The nibble after 0xD is the first data nibble.
- R3: Before lock, any nibble other than 0x5, or 0xD not directly preceded by 0x5, keeps the block hunting. A frame that never locks produces no byte and no frame-done pulse.
- R4: Each output byte is {second nibble, first nibble}: the nibble received first forms bits 3:0.
- R5: Bytes leave in received order, one out_valid pulse per complete byte.
- R6: The last complete byte of a frame leaves with out_last high, in the cycle after rx_dv is first sampled low. That is the same cycle as frm_done. No other byte has out_last.
- R7: If rx_er is sampled high in any cycle while rx_dv is high, frm_err is set and the last byte carries out_err high. out_err is high only on a last byte.
- R8: If rx_dv falls after an odd number of data nibbles, the partial byte is dropped and frm_misalign and frm_err are set. The last complete byte, if there is one, has out_err high.
- R9: col_out equals col_in and not full_duplex, one cycle later. crs_out equals crs_in one cycle later.
- R10: A locked frame with no complete data byte gives a frm_done pulse and no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| col_in | input | 1 | Raw collision indication |
| crs_in | input | 1 | Raw carrier sense |
| full_duplex | input | 1 | High selects full duplex (collision masked) |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Assembled byte |
| out_last | output | 1 | Final complete byte of the frame |
| out_err | output | 1 | Frame error, valid with out_last |
| frm_done | output | 1 | One-cycle end-of-frame pulse |
| frm_err | output | 1 | Frame had a receive error or misalignment |
| frm_misalign | output | 1 | Frame ended on an odd nibble |
| col_out | output | 1 | Masked, registered collision |
| crs_out | output | 1 | Registered carrier sense |

## Verification
Frames are sent with a full preamble, a one-byte preamble and only the delimiter. Identical output from all three shows that the lock depends only on the 0x5/0xD pair. Asymmetric data bytes such as 0xA1 would come out as 0x1A if the nibble order were reversed. A stream made of preamble nibbles followed by junk, with no delimiter, must produce nothing at all. Frames that end on an odd nibble, that carry an error strobe, or that have no data separate the three frame-status outcomes. Toggling duplex while collision is high shows the masking.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } hunt_st_t;
endpackage

// File: rtl/mii_rx_hunt.sv
module mii_rx_hunt
  import mii_rx_pkg::*;
#(
  parameter int              NIB_W   = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             data_nib_o,
  output logic             locked_o
);
  hunt_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!rx_dv) begin
      st_d = ST_HUNT;
    end else begin
      unique case (st_q)
        ST_HUNT: if (rxd == PRE_NIB) st_d = ST_PRE;
        ST_PRE: begin
          if (rxd == SFD_NIB)      st_d = ST_DATA;
          else if (rxd != PRE_NIB) st_d = ST_HUNT;
        end
        ST_DATA: st_d = ST_DATA;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HUNT;
    else        st_q <= st_d;
  end

  assign locked_o   = (st_q == ST_DATA);
  assign data_nib_o = locked_o & rx_dv;
endmodule

// File: rtl/mii_rx_pack.sv
module mii_rx_pack #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nib_v_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              frame_end_i,
  input  logic              err_i,
  output logic              half_o,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err
);
  logic              half_q, half_d;
  logic [NIB_W-1:0]  lo_q, lo_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hv_q, hv_d;
  logic              ov_d, ol_d, oe_d;
  logic [BYTE_W-1:0] od_d;
  logic              lo_en, hold_en, od_en;

  always_comb begin
    half_d  = half_q;
    lo_d    = lo_q;
    hold_d  = hold_q;
    hv_d    = hv_q;
    ov_d    = 1'b0;
    ol_d    = 1'b0;
    oe_d    = 1'b0;
    od_d    = out_data;
    lo_en   = 1'b0;
    hold_en = 1'b0;
    od_en   = 1'b0;
    if (frame_end_i) begin
      half_d = 1'b0;
      hv_d   = 1'b0;
      if (hv_q) begin
        ov_d  = 1'b1;
        od_d  = hold_q;
        od_en = 1'b1;
        ol_d  = 1'b1;
        oe_d  = err_i | half_q;
      end
    end else if (nib_v_i) begin
      if (!half_q) begin
        lo_d   = nib_i;
        lo_en  = 1'b1;
        half_d = 1'b1;
      end else begin
        half_d  = 1'b0;
        hold_d  = {nib_i, lo_q};
        hold_en = 1'b1;
        hv_d    = 1'b1;
        if (hv_q) begin
          ov_d  = 1'b1;
          od_d  = hold_q;
          od_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      lo_q      <= '0;
      hold_q    <= '0;
      hv_q      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      half_q    <= half_d;
      hv_q      <= hv_d;
      out_valid <= ov_d;
      out_last  <= ol_d;
      out_err   <= oe_d;
      if (lo_en)   lo_q     <= lo_d;
      if (hold_en) hold_q   <= hold_d;
      if (od_en)   out_data <= od_d;
    end
  end

  assign half_o = half_q;
endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_dv,
  input  logic rx_er,
  input  logic locked_i,
  input  logic half_i,
  input  logic col_in,
  input  logic crs_in,
  input  logic full_duplex,
  output logic frame_end_o,
  output logic err_o,
  output logic frm_done,
  output logic frm_err,
  output logic frm_misalign,
  output logic col_out,
  output logic crs_out
);
  logic err_q, err_d;
  logic done_d, ferr_d, mis_d, col_d, crs_d;

  always_comb begin
    frame_end_o = locked_i & ~rx_dv;
    err_d       = rx_dv ? (err_q | rx_er) : 1'b0;
    done_d      = frame_end_o;
    ferr_d      = frame_end_o & (err_q | half_i);
    mis_d       = frame_end_o & half_i;
    col_d       = col_in & ~full_duplex;
    crs_d       = crs_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q        <= 1'b0;
      frm_done     <= 1'b0;
      frm_err      <= 1'b0;
      frm_misalign <= 1'b0;
      col_out      <= 1'b0;
      crs_out      <= 1'b0;
    end else begin
      err_q        <= err_d;
      frm_done     <= done_d;
      frm_err      <= ferr_d;
      frm_misalign <= mis_d;
      col_out      <= col_d;
      crs_out      <= crs_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic              col_in,
  input  logic              crs_in,
  input  logic              full_duplex,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err,
  output logic              frm_done,
  output logic              frm_err,
  output logic              frm_misalign,
  output logic              col_out,
  output logic              crs_out
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       data_nib, locked, half, frame_end, err_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  mii_rx_hunt #(.NIB_W(NIB_W)) u_hunt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rx_dv      (rx_dv),
    .rxd        (rxd),
    .data_nib_o (data_nib),
    .locked_o   (locked)
  );

  mii_rx_pack #(.NIB_W(NIB_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .nib_v_i     (data_nib),
    .nib_i       (rxd),
    .frame_end_i (frame_end),
    .err_i       (err_flag),
    .half_o      (half),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .out_err     (out_err)
  );

  mii_rx_status u_stat (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .rx_dv        (rx_dv),
    .rx_er        (rx_er),
    .locked_i     (locked),
    .half_i       (half),
    .col_in       (col_in),
    .crs_in       (crs_in),
    .full_duplex  (full_duplex),
    .frame_end_o  (frame_end),
    .err_o        (err_flag),
    .frm_done     (frm_done),
    .frm_err      (frm_err),
    .frm_misalign (frm_misalign),
    .col_out      (col_out),
    .crs_out      (crs_out)
  );
endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_dv,
  input logic full_duplex,
  input logic out_valid,
  input logic out_last,
  input logic out_err,
  input logic frm_done,
  input logic frm_err,
  input logic frm_misalign,
  input logic col_out
);
  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && frm_done));
  // R6
  done_after_dv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> !$past(rx_dv));
  // R5
  mid_byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> $past(rx_dv));
  // R7
  err_only_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_last && frm_err));
  // R8
  misalign_is_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_misalign |-> (frm_err && frm_done));
  // R9
  col_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !col_out);
endmodule

bind mii_rx_deframer mii_rx_deframer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_dv        (rx_dv),
  .full_duplex  (full_duplex),
  .out_valid    (out_valid),
  .out_last     (out_last),
  .out_err      (out_err),
  .frm_done     (frm_done),
  .frm_err      (frm_err),
  .frm_misalign (frm_misalign),
  .col_out      (col_out)
);

// File: tb/sim_mii_rx_deframer.sv
`timescale 1ns/1ps
module sim_mii_rx_deframer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, col_in, crs_in, full_duplex;
  logic       out_valid, out_last, out_err, frm_done, frm_err, frm_misalign;
  logic       col_out, crs_out;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  logic [9:0] byte_q[$];  // {data, last, err}
  logic [1:0] stat_q[$];  // {err, misalign}
  logic       exp_col, exp_crs;

  always #10 clk = ~clk;

  mii_rx_deframer u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .col_in(col_in), .crs_in(crs_in), .full_duplex(full_duplex),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_err(out_err), .frm_done(frm_done), .frm_err(frm_err),
    .frm_misalign(frm_misalign), .col_out(col_out), .crs_out(crs_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference for the status pass-through, updated at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_col <= 1'b0;
      exp_crs <= 1'b0;
    end else begin
      exp_col <= col_in & ~full_duplex;
      exp_crs <= crs_in;
    end
  end

  // per-clock comparison against the queued expectations
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(col_out === exp_col, "R9 col_out", col_out, exp_col);
      chk(crs_out === exp_crs, "R9 crs_out", crs_out, exp_crs);
      if (out_valid) begin
        if (byte_q.size() == 0) begin
          chk(1'b0, "R3/R10 unexpected byte", out_data, 0);
        end else begin
          logic [9:0] e;
          e = byte_q.pop_front();
          chk(out_data === e[9:2], "R4/R5 byte value", out_data, e[9:2]);
          chk(out_last === e[1], "R6 last flag", out_last, e[1]);
          chk(out_err === e[0], "R7/R8 byte error flag", out_err, e[0]);
        end
      end
      if (frm_done) begin
        if (stat_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame status", 1, 0);
        end else begin
          logic [1:0] s;
          s = stat_q.pop_front();
          chk(frm_err === s[1], "R7/R8 frm_err", frm_err, s[1]);
          chk(frm_misalign === s[0], "R8 frm_misalign", frm_misalign, s[0]);
        end
      end
    end
  end

  task automatic drive(input logic [3:0] n, input bit er);
    @(negedge clk);
    rx_dv = 1'b1;
    rxd   = n;
    rx_er = er;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_dv = 1'b0;
      rx_er = 1'b0;
      rxd   = 4'h0;
    end
  endtask

  // npre preamble bytes, optional delimiter, data bytes, optional odd nibble,
  // er_nib = index of data nibble carrying rx_er (-1 none)
  task automatic send_frame(input int npre, input bit sfd, input logic [7:0] data[$],
                            input bit odd, input int er_nib);
    int k = 0;
    bit err = (er_nib >= 0);
    if (sfd) begin
      for (int i = 0; i < data.size(); i++)
        byte_q.push_back({data[i], (i == data.size() - 1), (i == data.size() - 1) & (err | odd)});
      stat_q.push_back({err | odd, odd});
    end
    for (int i = 0; i < 2 * npre; i++) drive(4'h5, 1'b0);
    if (sfd) begin
      drive(4'h5, 1'b0);
      drive(4'hD, 1'b0);
    end
    foreach (data[i]) begin
      drive(data[i][3:0], k == er_nib); k++;
      drive(data[i][7:4], k == er_nib); k++;
    end
    if (odd) begin
      drive(4'hA, k == er_nib);
    end
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; rxd = 4'h0; rx_dv = 1'b0; rx_er = 1'b0;
    col_in = 1'b0; crs_in = 1'b0; full_duplex = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({out_valid, out_last, out_err, frm_done, frm_err, frm_misalign, col_out, crs_out} === 8'h0,
        "R1 reset outputs", {out_valid, out_last, out_err, frm_done}, 0);
    col_in = 1'b1; crs_in = 1'b1;
    @(negedge clk);
    chk(col_out === 1'b0 && crs_out === 1'b0, "R1 outputs held in reset", col_out, 0);
    col_in = 1'b0; crs_in = 1'b0;
    rst_n = 1'b1;
    idle(5);

    // R2 R4 R5 R6: full preamble, asymmetric bytes
    send_frame(7, 1, '{8'hA1, 8'h3C, 8'hD5, 8'h55, 8'h0F, 8'hE7}, 0, -1);
    // R2: shortened preamble, single byte
    send_frame(1, 1, '{8'h96}, 0, -1);
    // R2: delimiter only
    send_frame(0, 1, '{8'h12, 8'h34, 8'hF0}, 0, -1);
    // R3: preamble followed by junk, no delimiter
    send_frame(3, 0, '{8'h37, 8'h9C, 8'hE1}, 0, -1);
    // R3: 0xD without a preceding 0x5 then junk
    drive(4'hD, 0); drive(4'h7, 0); drive(4'hD, 0); idle(3);
    // R7: error strobe mid-data
    send_frame(2, 1, '{8'h11, 8'h22, 8'h33}, 0, 3);
    // R8: odd nibble count
    send_frame(7, 1, '{8'h4B, 8'hC2}, 1, -1);
    // R10: locked frame with no data
    send_frame(2, 1, '{}, 0, -1);
    // R8 R10: single stray nibble only
    send_frame(0, 1, '{}, 1, -1);
    // R7: error on the very last nibble
    send_frame(1, 1, '{8'h80, 8'h08}, 0, 3);
    // clean frame after errors: flags cleared
    send_frame(4, 1, '{8'h5A, 8'hA5}, 0, -1);

    // R9 collision masking under both duplex settings
    col_in = 1'b1; crs_in = 1'b1; full_duplex = 1'b0;
    idle(3);
    chk(col_out === 1'b1, "R9 col passes in half duplex", col_out, 1);
    full_duplex = 1'b1;
    idle(3);
    chk(col_out === 1'b0, "R9 col masked in full duplex", col_out, 0);
    chk(crs_out === 1'b1, "R9 crs passes", crs_out, 1);
    col_in = 1'b0; crs_in = 1'b0; full_duplex = 1'b0;
    idle(4);

    chk(byte_q.size() == 0, "R5 all bytes delivered", byte_q.size(), 0);
    chk(stat_q.size() == 0, "R6/R10 all frames reported", stat_q.size(), 0);
    summary();
  end
endmodule